// File: doc/BRIEF.md
# Crossing History Buffer with Zero-Suppressed Readout

The block keeps a short history of calorimeter tower energy words, one 16-bit word per tower for every beam crossing, in a circular store of `DEPTH` crossings. The accept decision for a crossing arrives some crossings later. When it does, the block looks back a programmable number of crossings to find the triggered one. It then reads out that crossing together with an optional window of earlier and later crossings.

Every event on the output stream has three parts: a header word, a body and a trailer word. The header records the settings in force for the event. The trailer carries the body length and is the only word marked last. The body holds either every tower word of the window or, when suppression is selected, an address/data pair for each nonzero word only. The output is a valid/ready stream. Accepts that arrive during a readout wait in a two-entry queue, and each one keeps the settings that were present when it arrived. Settings that would reach into crossings not yet complete, or into crossings already overwritten, are clamped and flagged.

Top module: `xing_hist_zs`

## Requirements
- R1: A `xing_strobe` pulse advances the write slot by one (modulo `DEPTH`) and restarts the tower count. Each `tw_valid` cycle stores `tw_data` for the next tower in ascending order. Words beyond `NTOW` in one crossing are ignored.
- R2: An accept takes the current crossing C (the one being filled) and reads crossings C-L-P through C-L+Q, oldest first, towers ascending within each crossing. Here L, P and Q are the effective latency, pre-window and post-window.
- R3: In full mode an event is the header, then all (P+Q+1)*NTOW tower words, then a trailer equal to the body word count.
- R4: In suppressed mode the body has, for each nonzero tower word only, an address word followed at once by the data word. The address word holds the window position (0 = oldest) in bits [15:8] and the tower index in the low bits. The trailer equals twice the number of pairs.
- R5: The header word holds the suppression flag in bit 15, P in bits [8:7], Q in bits [6:5] and L in bits [4:0], with all other bits zero.
- R6: The effective latency is L = max(cfg_lat, cfg_post+1). The effective pre-window is P = min(cfg_pre, DEPTH-1-L). `cfg_clamped` is high one cycle after any setting has been changed by these rules.
- R7: Accepts arriving while a readout runs are queued, up to two of them. They are served in arrival order, each with the settings and the current crossing sampled in its own accept cycle.
- R8: An accept arriving with the queue full and no entry leaving is dropped. It also sets `acc_overflow`, which stays set until reset.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values. `out_last` is high only on a trailer word.
- R10: During reset `out_valid`, `acc_overflow` and `cfg_clamped` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xing_strobe | input | 1 | Start of a new beam crossing |
| tw_valid | input | 1 | Tower word present |
| tw_data | input | 16 | Tower energy word |
| accept | input | 1 | Accept pulse for the crossing one latency back |
| cfg_lat | input | 5 | Requested latency in crossings |
| cfg_pre | input | 2 | Crossings read before the triggered one |
| cfg_post | input | 2 | Crossings read after the triggered one |
| cfg_zs | input | 1 | Select address/data pairs for nonzero words |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 16 | Output word |
| out_last | output | 1 | Trailer word of an event |
| cfg_clamped | output | 1 | Settings were adjusted by the clamp rules |
| acc_overflow | output | 1 | Sticky: an accept was lost |

## Verification
Several properties are checked on every cycle:
- the output holds its word under backpressure;
- the overflow flag never clears and only rises after an accept;
- the clamped latency always exceeds the post-window;
- latency plus pre-window never exceeds the history span.

Other behaviours only the bench scenarios can show. These are the content and order of each event, the skipping of zero words, the address-word fields, the header and trailer values, the per-accept capture of settings in the queue, and the lost fourth accept. The bench shows them by sweeping every latency, window and mode over a history that has wrapped.

// File: rtl/xhb_pkg.sv
package xhb_pkg;
  timeunit 1ns; timeprecision 1ps;
  localparam int WORD_W     = 16;
  localparam int ADDR_SPLIT = 8;
  typedef enum logic [2:0] {RO_IDLE, RO_HDR, RO_SCAN, RO_DATA, RO_TRL} ro_state_e;
endpackage

// File: rtl/xhb_history.sv
module xhb_history import xhb_pkg::*; #(
  parameter  int DEPTH = 32,
  parameter  int NTOW  = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int TW_W  = $clog2(NTOW),
  localparam int CW    = $clog2(NTOW + 1),
  localparam int MA_W  = $clog2(DEPTH * NTOW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xing_strobe,
  input  logic              tw_valid,
  input  logic [WORD_W-1:0] tw_data,
  output logic [PTR_W-1:0]  wr_slot,
  input  logic [PTR_W-1:0]  rd_slot,
  input  logic [TW_W-1:0]   rd_tow,
  output logic [WORD_W-1:0] rd_data
);
  logic [PTR_W-1:0]  slot_q, slot_d;
  logic [CW-1:0]     tcnt_q, tcnt_d, tcnt_base;
  logic              wr_en;
  logic [MA_W-1:0]   wa, ra;
  logic [WORD_W-1:0] mem [DEPTH*NTOW];

  // next-state: slot advance and tower counter
  always_comb begin
    slot_d    = slot_q;
    tcnt_base = tcnt_q;
    if (xing_strobe) begin
      slot_d    = (slot_q == PTR_W'(DEPTH - 1)) ? '0 : slot_q + 1'b1;
      tcnt_base = '0;
    end
    wr_en  = tw_valid && (tcnt_base < CW'(NTOW));
    tcnt_d = tcnt_base + CW'(wr_en);
    wa     = MA_W'(slot_d) * MA_W'(NTOW) + MA_W'(tcnt_base[TW_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      tcnt_q <= '0;
    end else begin
      slot_q <= slot_d;
      tcnt_q <= tcnt_d;
    end
  end

  // storage array, no reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[wa] <= tw_data;
  end

  assign ra      = MA_W'(rd_slot) * MA_W'(NTOW) + MA_W'(rd_tow);
  assign rd_data = mem[ra];
  assign wr_slot = slot_q;
endmodule

// File: rtl/xhb_cfg_clamp.sv
module xhb_cfg_clamp #(
  parameter  int DEPTH = 32,
  parameter  int WIN_W = 2,
  localparam int LAT_W = $clog2(DEPTH),
  localparam int SW    = LAT_W + 1
) (
  input  logic [LAT_W-1:0] lat,
  input  logic [WIN_W-1:0] pre,
  input  logic [WIN_W-1:0] post,
  output logic [LAT_W-1:0] lat_eff,
  output logic [WIN_W-1:0] pre_eff,
  output logic [WIN_W-1:0] post_eff,
  output logic             clamped
);
  logic [SW-1:0] need_lat, span;

  always_comb begin
    post_eff = post;
    // later crossings must already be complete
    need_lat = SW'(post) + SW'(1);
    lat_eff  = (SW'(lat) < need_lat) ? LAT_W'(need_lat) : lat;
    // earliest crossing must still be held
    span     = SW'(lat_eff) + SW'(pre);
    if (span > SW'(DEPTH - 1)) pre_eff = WIN_W'(SW'(DEPTH - 1) - SW'(lat_eff));
    else                       pre_eff = pre;
    clamped  = (lat_eff != lat) || (pre_eff != pre);
  end
endmodule

// File: rtl/xhb_acc_q.sv
module xhb_acc_q #(
  parameter int EW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [EW-1:0] din,
  input  logic          pop,
  output logic [EW-1:0] dout,
  output logic          nonempty,
  output logic          ovf
);
  logic [EW-1:0] e0_q, e0_d, e1_q, e1_d;
  logic [1:0]    cnt_q, cnt_d, cnt_p;
  logic          ovf_q, ovf_d, do_pop, do_push;

  always_comb begin
    do_pop  = pop && (cnt_q != 2'd0);
    do_push = push && ((cnt_q != 2'd2) || do_pop);
    cnt_p   = cnt_q - 2'(do_pop);
    e0_d    = do_pop ? e1_q : e0_q;
    e1_d    = e1_q;
    if (do_push) begin
      if (cnt_p == 2'd0) e0_d = din;
      else               e1_d = din;
    end
    cnt_d = cnt_p + 2'(do_push);
    ovf_d = ovf_q | (push && !do_push);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  // entry payload, clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (do_pop || do_push) begin
      e0_q <= e0_d;
      e1_q <= e1_d;
    end
  end

  assign dout     = e0_q;
  assign nonempty = (cnt_q != 2'd0);
  assign ovf      = ovf_q;
endmodule

// File: rtl/xhb_readout.sv
module xhb_readout import xhb_pkg::*; #(
  parameter  int DEPTH = 32,
  parameter  int NTOW  = 4,
  parameter  int WIN_W = 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int TW_W  = $clog2(NTOW),
  localparam int K_W   = WIN_W + 1,
  localparam int SL_W  = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_nonempty,
  input  logic [PTR_W-1:0]  q_base,
  input  logic [K_W-1:0]    q_nxm1,
  input  logic              q_zs,
  input  logic [WORD_W-1:0] q_hdr,
  output logic              q_pop,
  output logic [PTR_W-1:0]  rd_slot,
  output logic [TW_W-1:0]   rd_tow,
  input  logic [WORD_W-1:0] rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last
);
  ro_state_e         st_q, st_d;
  logic [PTR_W-1:0]  base_q, base_d;
  logic [K_W-1:0]    nxm1_q, nxm1_d, k_q, k_d;
  logic              zs_q, zs_d;
  logic [WORD_W-1:0] hdr_q, hdr_d, cnt_q, cnt_d, addr_word;
  logic [TW_W-1:0]   t_q, t_d;
  logic [SL_W-1:0]   slot_sum;
  logic              at_end, adv;

  always_comb begin
    slot_sum = {1'b0, base_q} + SL_W'(k_q);
    rd_slot  = (slot_sum >= SL_W'(DEPTH)) ? PTR_W'(slot_sum - SL_W'(DEPTH)) : PTR_W'(slot_sum);
    rd_tow   = t_q;
    at_end   = (t_q == TW_W'(NTOW - 1)) && (k_q == nxm1_q);
    addr_word = '0;
    addr_word[WORD_W-1:ADDR_SPLIT] = (WORD_W-ADDR_SPLIT)'(k_q);
    addr_word[TW_W-1:0]            = t_q;
  end

  // next-state and output decode
  always_comb begin
    st_d = st_q; base_d = base_q; nxm1_d = nxm1_q; zs_d = zs_q; hdr_d = hdr_q;
    k_d = k_q; t_d = t_q; cnt_d = cnt_q;
    q_pop = 1'b0; adv = 1'b0;
    out_valid = 1'b0; out_data = '0; out_last = 1'b0;
    unique case (st_q)
      RO_IDLE: begin
        if (q_nonempty) begin
          q_pop  = 1'b1;
          base_d = q_base; nxm1_d = q_nxm1; zs_d = q_zs; hdr_d = q_hdr;
          k_d = '0; t_d = '0; cnt_d = '0;
          st_d = RO_HDR;
        end
      end
      RO_HDR: begin
        out_valid = 1'b1;
        out_data  = hdr_q;
        if (out_ready) st_d = RO_SCAN;
      end
      RO_SCAN: begin
        if (!zs_q) begin
          out_valid = 1'b1;
          out_data  = rd_data;
          if (out_ready) begin
            cnt_d = cnt_q + 1'b1;
            adv   = 1'b1;
          end
        end else if (rd_data != '0) begin
          out_valid = 1'b1;
          out_data  = addr_word;
          if (out_ready) st_d = RO_DATA;
        end else begin
          adv = 1'b1;
        end
      end
      RO_DATA: begin
        out_valid = 1'b1;
        out_data  = rd_data;
        if (out_ready) begin
          cnt_d = cnt_q + WORD_W'(2);
          adv   = 1'b1;
        end
      end
      RO_TRL: begin
        out_valid = 1'b1;
        out_data  = cnt_q;
        out_last  = 1'b1;
        if (out_ready) st_d = RO_IDLE;
      end
      default: st_d = RO_IDLE;
    endcase
    if (adv) begin
      if (at_end) begin
        st_d = RO_TRL;
      end else begin
        st_d = RO_SCAN;
        if (t_q == TW_W'(NTOW - 1)) begin
          t_d = '0;
          k_d = k_q + 1'b1;
        end else begin
          t_d = t_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RO_IDLE;
      k_q  <= '0;
      t_q  <= '0;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      k_q  <= k_d;
      t_q  <= t_d;
      cnt_q <= cnt_d;
    end
  end

  // event context, loaded on pop only
  always_ff @(posedge clk) begin
    if (q_pop) begin
      base_q <= base_d;
      nxm1_q <= nxm1_d;
      zs_q   <= zs_d;
      hdr_q  <= hdr_d;
    end
  end
endmodule

// File: rtl/xing_hist_zs.sv
module xing_hist_zs import xhb_pkg::*; #(
  parameter  int DEPTH = 32,
  parameter  int NTOW  = 4,
  parameter  int WIN_W = 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LAT_W = PTR_W,
  localparam int TW_W  = $clog2(NTOW),
  localparam int K_W   = WIN_W + 1,
  localparam int SL_W  = PTR_W + 1,
  localparam int EW    = PTR_W + K_W + 1 + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xing_strobe,
  input  logic              tw_valid,
  input  logic [WORD_W-1:0] tw_data,
  input  logic              accept,
  input  logic [LAT_W-1:0]  cfg_lat,
  input  logic [WIN_W-1:0]  cfg_pre,
  input  logic [WIN_W-1:0]  cfg_post,
  input  logic              cfg_zs,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              cfg_clamped,
  output logic              acc_overflow
);
  logic [1:0]        rs_q;
  logic              rst_sync_n;
  logic [PTR_W-1:0]  wr_slot, rd_slot, base_in, q_base;
  logic [TW_W-1:0]   rd_tow;
  logic [WORD_W-1:0] rd_data, hdr_in, q_hdr;
  logic [LAT_W-1:0]  lat_eff;
  logic [WIN_W-1:0]  pre_eff, post_eff;
  logic              clamp_w, clamp_q, q_nonempty, q_pop, q_zs;
  logic [K_W-1:0]    nxm1_in, q_nxm1;
  logic [SL_W-1:0]   base_w;
  logic [EW-1:0]     q_din, q_dout;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  xhb_history #(.DEPTH(DEPTH), .NTOW(NTOW)) u_hist (
    .clk(clk), .rst_n(rst_sync_n), .xing_strobe(xing_strobe), .tw_valid(tw_valid),
    .tw_data(tw_data), .wr_slot(wr_slot), .rd_slot(rd_slot), .rd_tow(rd_tow),
    .rd_data(rd_data)
  );

  xhb_cfg_clamp #(.DEPTH(DEPTH), .WIN_W(WIN_W)) u_clamp (
    .lat(cfg_lat), .pre(cfg_pre), .post(cfg_post), .lat_eff(lat_eff),
    .pre_eff(pre_eff), .post_eff(post_eff), .clamped(clamp_w)
  );

  // queue entry formed in the accept cycle
  always_comb begin
    base_w  = {1'b0, wr_slot} + SL_W'(DEPTH) - SL_W'(lat_eff) - SL_W'(pre_eff);
    base_in = (base_w >= SL_W'(DEPTH)) ? PTR_W'(base_w - SL_W'(DEPTH)) : PTR_W'(base_w);
    nxm1_in = K_W'(pre_eff) + K_W'(post_eff);
    hdr_in  = '0;
    hdr_in[WORD_W-1]               = cfg_zs;
    hdr_in[LAT_W-1:0]              = lat_eff;
    hdr_in[LAT_W +: WIN_W]         = post_eff;
    hdr_in[LAT_W + WIN_W +: WIN_W] = pre_eff;
    q_din   = {base_in, nxm1_in, cfg_zs, hdr_in};
  end

  xhb_acc_q #(.EW(EW)) u_q (
    .clk(clk), .rst_n(rst_sync_n), .push(accept), .din(q_din), .pop(q_pop),
    .dout(q_dout), .nonempty(q_nonempty), .ovf(acc_overflow)
  );
  assign {q_base, q_nxm1, q_zs, q_hdr} = q_dout;

  xhb_readout #(.DEPTH(DEPTH), .NTOW(NTOW), .WIN_W(WIN_W)) u_ro (
    .clk(clk), .rst_n(rst_sync_n), .q_nonempty(q_nonempty), .q_base(q_base),
    .q_nxm1(q_nxm1), .q_zs(q_zs), .q_hdr(q_hdr), .q_pop(q_pop), .rd_slot(rd_slot),
    .rd_tow(rd_tow), .rd_data(rd_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) clamp_q <= 1'b0;
    else             clamp_q <= clamp_w;
  end
  assign cfg_clamped = clamp_q;
endmodule

// File: rtl/xing_hist_zs_chk.sv
module xing_hist_zs_chk #(
  parameter  int DEPTH = 32,
  parameter  int WIN_W = 2,
  localparam int LAT_W = $clog2(DEPTH),
  localparam int SW    = LAT_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             out_valid,
  input logic             out_ready,
  input logic [15:0]      out_data,
  input logic             out_last,
  input logic             acc_overflow,
  input logic [LAT_W-1:0] lat_eff,
  input logic [WIN_W-1:0] pre_eff,
  input logic [WIN_W-1:0] post_eff
);
  timeunit 1ns; timeprecision 1ps;

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  p_last_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_overflow |=> acc_overflow);

  p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_overflow) |-> $past(accept));

  p_lat_covers_post_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lat_eff > LAT_W'(post_eff));

  p_span_in_depth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (SW'(lat_eff) + SW'(pre_eff)) <= SW'(DEPTH - 1));

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !acc_overflow));
endmodule

bind xing_hist_zs xing_hist_zs_chk #(.DEPTH(DEPTH), .WIN_W(WIN_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .accept(accept), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .acc_overflow(acc_overflow), .lat_eff(lat_eff), .pre_eff(pre_eff),
  .post_eff(post_eff)
);

// File: tb/sim_xing_hist_zs.sv
module sim_xing_hist_zs;
  timeunit 1ns; timeprecision 1ps;
  localparam int DEPTH = 32, NTOW = 4, WIN_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic xing_strobe = 0, tw_valid = 0, accept = 0, cfg_zs = 0, out_ready = 0;
  logic [15:0] tw_data = '0;
  logic [4:0]  cfg_lat = '0;
  logic [1:0]  cfg_pre = '0, cfg_post = '0;
  logic out_valid, out_last, cfg_clamped, acc_overflow;
  logic [15:0] out_data;

  int checks = 0, errors = 0, cur = -1;
  logic [15:0] exp_w [0:255];
  logic [15:0] got_w [0:255];
  logic        got_l [0:255];
  int exp_n, got_n;

  always #2 clk = ~clk;

  xing_hist_zs #(.DEPTH(DEPTH), .NTOW(NTOW), .WIN_W(WIN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .xing_strobe(xing_strobe), .tw_valid(tw_valid),
    .tw_data(tw_data), .accept(accept), .cfg_lat(cfg_lat), .cfg_pre(cfg_pre),
    .cfg_post(cfg_post), .cfg_zs(cfg_zs), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .cfg_clamped(cfg_clamped),
    .acc_overflow(acc_overflow)
  );

  function automatic logic [15:0] fval(int c, int t);
    return ((c + t) % 3 == 0) ? 16'h0000 : 16'(c * 16 + t + 1);
  endfunction

  task automatic check1(string req, logic [15:0] act, logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, expv);
    end
  endtask

  // R1: write crossings, with surplus words on some
  task automatic write_crossings(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); xing_strobe = 1'b1;
      @(negedge clk); xing_strobe = 1'b0; cur++;
      for (int t = 0; t < NTOW; t++) begin
        tw_valid = 1'b1; tw_data = fval(cur, t);
        @(negedge clk);
      end
      if (cur % 4 == 0) begin tw_data = 16'hFFFF; @(negedge clk); end
      tw_valid = 1'b0;
    end
  endtask

  // expected event from the requirements (R2..R6)
  task automatic build_exp(int lat, int pre, int post, int zs);
    int le, pe, trig, body;
    le = (lat < post + 1) ? post + 1 : lat;
    pe = (le + pre > DEPTH - 1) ? DEPTH - 1 - le : pre;
    trig = cur - le;
    exp_n = 0;
    exp_w[exp_n++] = 16'((zs << 15) | (pe << 7) | (post << 5) | le);
    body = 0;
    for (int k = 0; k <= pe + post; k++) begin
      for (int t = 0; t < NTOW; t++) begin
        logic [15:0] v;
        v = fval(trig - pe + k, t);
        if (zs == 0) begin
          exp_w[exp_n++] = v; body++;
        end else if (v != 0) begin
          exp_w[exp_n++] = 16'((k << 8) | t);
          exp_w[exp_n++] = v; body += 2;
        end
      end
    end
    exp_w[exp_n++] = 16'(body);
  endtask

  task automatic fire(int lat, int pre, int post, int zs);
    @(negedge clk);
    out_ready = 1'b0;
    cfg_lat = 5'(lat); cfg_pre = 2'(pre); cfg_post = 2'(post); cfg_zs = zs[0];
    accept = 1'b1;
    @(negedge clk);
    accept = 1'b0;
  endtask

  task automatic collect(int bp);
    bit seen;
    int guard;
    seen = 0; guard = 0; got_n = 0;
    while (!seen && guard < 600) begin
      @(negedge clk);
      out_ready = (bp != 0) ? (guard % 3 != 1) : 1'b1;
      #1;
      if (out_valid && out_ready) begin
        got_w[got_n] = out_data; got_l[got_n] = out_last;
        got_n++;
        if (out_last) seen = 1;
      end
      guard++;
    end
  endtask

  task automatic compare(string req);
    bit ok;
    int bad;
    ok = (got_n == exp_n); bad = -1;
    for (int i = 0; i < got_n && i < exp_n; i++) begin
      if (got_w[i] !== exp_w[i] || got_l[i] !== (i == exp_n - 1)) begin
        if (bad < 0) bad = i;
        ok = 0;
      end
    end
    checks++;
    if (!ok) begin
      errors++;
      if (bad >= 0)
        $display("FAIL %s word %0d actual %h last %0d expected %h", req, bad,
                 got_w[bad], got_l[bad], exp_w[bad]);
      else
        $display("FAIL %s word count actual %0d expected %0d", req, got_n, exp_n);
    end
  endtask

  task automatic clamp_case(int lat, int pre, int post, logic expv);
    @(negedge clk);
    cfg_lat = 5'(lat); cfg_pre = 2'(pre); cfg_post = 2'(post);
    @(negedge clk);
    check1("R6 clamp flag", {15'b0, cfg_clamped}, {15'b0, expv});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int vcount;
    repeat (3) @(negedge clk);
    // R10: quiet during reset
    check1("R10 out_valid", {15'b0, out_valid}, 16'h0);
    check1("R10 acc_overflow", {15'b0, acc_overflow}, 16'h0);
    check1("R10 cfg_clamped", {15'b0, cfg_clamped}, 16'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R6 clamp boundaries
    clamp_case(0, 0, 2, 1'b1);
    clamp_case(10, 1, 1, 1'b0);
    clamp_case(31, 3, 0, 1'b1);
    clamp_case(28, 3, 0, 1'b0);

    // fill past one wrap of the history (R1)
    write_crossings(40);

    // R1 R2 R3 R4 R5 R9: every latency, window and mode
    for (int zs = 0; zs < 2; zs++)
      for (int lat = 0; lat < 32; lat++)
        for (int pre = 0; pre < 4; pre++)
          for (int post = 0; post < 4; post++) begin
            fire(lat, pre, post, zs);
            build_exp(lat, pre, post, zs);
            collect((lat + pre + post) % 2);
            compare(zs != 0 ? "R1 R2 R4 R5 R9 zs event" : "R1 R2 R3 R5 R9 full event");
          end

    // R7: three back-to-back accepts, each with its own settings
    @(negedge clk); out_ready = 1'b0;
    cfg_lat = 5'd5; cfg_pre = 2'd1; cfg_post = 2'd1; cfg_zs = 1'b0; accept = 1'b1;
    @(negedge clk); cfg_lat = 5'd6; cfg_zs = 1'b1;
    @(negedge clk); cfg_lat = 5'd7; cfg_post = 2'd0; cfg_zs = 1'b0;
    @(negedge clk); accept = 1'b0;
    build_exp(5, 1, 1, 0); collect(0); compare("R7 queued event 1");
    build_exp(6, 1, 1, 1); collect(1); compare("R7 queued event 2");
    build_exp(7, 1, 0, 0); collect(0); compare("R7 queued event 3");
    check1("R7 no overflow at two queued", {15'b0, acc_overflow}, 16'h0);

    // R8: fourth accept is lost and flagged
    @(negedge clk); out_ready = 1'b0;
    cfg_pre = 2'd0; cfg_post = 2'd0; cfg_zs = 1'b0;
    cfg_lat = 5'd3; accept = 1'b1;
    @(negedge clk); cfg_lat = 5'd4;
    @(negedge clk); cfg_lat = 5'd5;
    @(negedge clk); cfg_lat = 5'd6;
    @(negedge clk); accept = 1'b0;
    check1("R8 overflow set", {15'b0, acc_overflow}, 16'h1);
    build_exp(3, 0, 0, 0); collect(0); compare("R8 event 1");
    build_exp(4, 0, 0, 0); collect(0); compare("R8 event 2");
    build_exp(5, 0, 0, 0); collect(0); compare("R8 event 3");
    vcount = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); out_ready = 1'b1; #1;
      if (out_valid) vcount++;
    end
    check1("R8 dropped accept emits nothing", 16'(vcount), 16'h0);

    // R8 sticky after a further normal event
    fire(9, 2, 1, 1); build_exp(9, 2, 1, 1); collect(1); compare("R8 R4 later event");
    check1("R8 overflow sticky", {15'b0, acc_overflow}, 16'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule